// File: doc/BRIEF.md
# Dual Masked Alarm Comparator with Shared Interrupt/Frequency Pin

This block watches the live calendar time and compares it with two alarm targets. Each target carries a per-field compare mask covering second, minute, hour, weekday, day of month and month, so an alarm can match a full date and time or only a partial pattern such as "every minute at second 30" or "every weekday 2". The comparison is evaluated only on the once-per-second advance strobe from the timekeeping counters, so a match produces exactly one event per second. A matching event sets a sticky per-alarm flag that a host polls and clears with a strobe.

Each alarm is armed by a strobe. In one-shot mode it disarms itself when it fires. In repeat mode it stays armed and fires again at every later match, which gives periodic interrupts. A single output pin either carries an active-low interrupt, driven by flags whose interrupt enable is set, or one of three square waves supplied by the divider chain. A two-bit selector chooses the pin function.

The counters, the nonvolatile storage of the alarm targets and the host bus interface sit outside this block and connect through plain ports.

Top module: `rtc_alarm_unit`

## Requirements
- R1: The time word is packed as {month[3:0], date[4:0], weekday[2:0], hour[4:0], minute[5:0], second[5:0]} with second at the LSB. An armed alarm whose compared fields all equal the live time sets its flag on the clock edge that samples `sec_tick` high. A mismatch in any compared field sets no flag.
- R2: Mask bit k of an alarm enables the compare of one field: bit 0 second, 1 minute, 2 hour, 3 weekday, 4 date, 5 month. A field whose bit is 0 is ignored, and a field whose bit is 1 must match.
- R3: An alarm whose six mask bits are all 0 never fires, even while armed.
- R4: Without `sec_tick` no alarm fires, even when the live time matches.
- R5: With repeat off, firing clears the alarm's armed state on the same edge. An alarm that is not armed does not fire.
- R6: With repeat on, the alarm stays armed after firing and fires again at the next matching strobe.
- R7: Flags are sticky until the alarm's clear strobe. When a fire and a clear of the same alarm happen on the same edge, the flag is set.
- R8: An arm strobe sets the armed state on the next edge. It takes priority over the one-shot self-disarm on the same edge.
- R9: With `pin_sel` = 2'b00, `pin_out` is low one cycle after any flag whose interrupt enable is 1, and high otherwise. A flag whose interrupt enable is 0 does not drive the pin.
- R10: With `pin_sel` set to 2'b01, 2'b10 or 2'b11, `pin_out` follows `wave_32k`, `wave_100hz` or `wave_1hz` respectively, one cycle late.
- R11: After reset, all armed states and flags are 0 and `pin_out` is 1.
- R12: The two alarms are independent: the fire, arm or clear of one never changes the other's flag or armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe when the seconds count advances |
| live_time | input | 29 | Current time word, layout in R1 |
| alm_time | input | 2*29 | Alarm targets, alarm i at bits [i*29 +: 29] |
| alm_fmask | input | 2*6 | Field compare masks, alarm i at bits [i*6 +: 6] |
| alm_repeat | input | 2 | Per-alarm repeat mode |
| alm_arm | input | 2 | Per-alarm arm strobe |
| alm_irq_en | input | 2 | Per-alarm interrupt enable |
| flag_clr | input | 2 | Per-alarm flag clear strobe |
| pin_sel | input | 2 | Pin function select |
| wave_1hz | input | 1 | 1 Hz square wave from divider |
| wave_100hz | input | 1 | 100 Hz square wave from divider |
| wave_32k | input | 1 | 32.768 kHz square wave from divider |
| alm_armed | output | 2 | Per-alarm armed state |
| alm_flag | output | 2 | Per-alarm sticky match flag |
| pin_out | output | 1 | Active-low interrupt or selected wave |

## Verification
The compare is tested with a full six-field match, with a single-field mask on second, with a single-field mask on weekday against a differing weekday, and with an all-zero mask. This separates correct mask decoding from a compare that ignores the masks or from one that treats an empty mask as a wildcard. Matching times presented without the strobe separate the strobe gating from a level-sensitive compare. Same-edge collisions (fire with clear, fire with arm) fix the priorities. Each pin-select code is driven with the three waves in distinct states, which shows that every code routes the intended source.

// File: rtl/rtc_alarm_pkg.sv
// Package: shared time-word layout, pin-select codes and field compare helper.
// Assumes binary-coded fields supplied by the timekeeping counters.
package rtc_alarm_pkg;

    localparam int NUM_FIELDS = 6;

    // Time word; second sits at the LSB, month at the MSB.
    typedef struct packed {
        logic [3:0] mon;
        logic [4:0] date;
        logic [2:0] dow;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } rtc_time_t;

    localparam int TIME_W = $bits(rtc_time_t);

    typedef enum logic [1:0] {
        PIN_IRQ   = 2'b00,
        PIN_32K   = 2'b01,
        PIN_100HZ = 2'b10,
        PIN_1HZ   = 2'b11
    } pin_sel_e;

    // Per-field equality; bit order matches the mask bit order.
    function automatic logic [NUM_FIELDS-1:0] field_equal(input rtc_time_t a, input rtc_time_t b);
        field_equal = {a.mon == b.mon, a.date == b.date, a.dow == b.dow,
                       a.hour == b.hour, a.min == b.min, a.sec == b.sec};
    endfunction

endpackage

// File: rtl/alarm_match.sv
// Module: combinational masked compare of one alarm target against live time.
// Assumes: mask bit set = field compared; an empty mask never matches.
module alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic [TIME_W-1:0]     live_time,
    input  logic [TIME_W-1:0]     target,
    input  logic [NUM_FIELDS-1:0] fmask,
    output logic                  hit
);

    logic [NUM_FIELDS-1:0] eq;

    // Field-by-field equality of live time and target.
    always_comb eq = field_equal(rtc_time_t'(live_time), rtc_time_t'(target));

    // Hit when at least one field is compared and every compared field agrees.
    always_comb hit = (|fmask) && (&(eq | ~fmask));

endmodule

// File: rtl/alarm_slot.sv
// Module: armed state and sticky flag of one alarm.
// Assumes: sec_tick is a single-cycle strobe; arm beats self-disarm, fire beats clear.
module alarm_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic hit,
    input  logic repeat_en,
    input  logic arm,
    input  logic clr,
    output logic armed,
    output logic flag
);

    logic fire;

    // A fire needs an armed alarm, a match and the seconds strobe.
    always_comb fire = sec_tick && hit && armed;

    // Armed state: set by arm strobe, dropped after a one-shot fire.
    always_ff @(posedge clk) begin
        if (!rst_n)                armed <= 1'b0;
        else if (arm)              armed <= 1'b1;
        else if (fire && !repeat_en) armed <= 1'b0;
    end

    // Sticky flag: set by fire, cleared by host strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (fire) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

endmodule

// File: rtl/pin_mux.sv
// Module: registered selector for the shared output pin.
// Assumes: wave inputs are already synchronous to clk; pin idles high.
module pin_mux
    import rtc_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pin_sel,
    input  logic       irq_req,
    input  logic       wave_1hz,
    input  logic       wave_100hz,
    input  logic       wave_32k,
    output logic       pin_out
);

    logic pin_d;

    // Choose the active-low interrupt or one of the divider waves.
    always_comb begin
        unique case (pin_sel_e'(pin_sel))
            PIN_IRQ:   pin_d = ~irq_req;
            PIN_32K:   pin_d = wave_32k;
            PIN_100HZ: pin_d = wave_100hz;
            PIN_1HZ:   pin_d = wave_1hz;
            default:   pin_d = 1'b1;
        endcase
    end

    // Register the pin so it is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_out <= 1'b1;
        else        pin_out <= pin_d;
    end

endmodule

// File: rtl/rtc_alarm_unit.sv
// Module: top of the alarm unit; NUM_ALARMS masked alarms sharing one output pin.
// Assumes: alarm targets and masks are held stable by external storage.
module rtc_alarm_unit
    import rtc_alarm_pkg::*;
#(
    parameter int NUM_ALARMS = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             sec_tick,
    input  logic [TIME_W-1:0]                live_time,
    input  logic [NUM_ALARMS*TIME_W-1:0]     alm_time,
    input  logic [NUM_ALARMS*NUM_FIELDS-1:0] alm_fmask,
    input  logic [NUM_ALARMS-1:0]            alm_repeat,
    input  logic [NUM_ALARMS-1:0]            alm_arm,
    input  logic [NUM_ALARMS-1:0]            alm_irq_en,
    input  logic [NUM_ALARMS-1:0]            flag_clr,
    input  logic [1:0]                       pin_sel,
    input  logic                             wave_1hz,
    input  logic                             wave_100hz,
    input  logic                             wave_32k,
    output logic [NUM_ALARMS-1:0]            alm_armed,
    output logic [NUM_ALARMS-1:0]            alm_flag,
    output logic                             pin_out
);

    logic [NUM_ALARMS-1:0] hit;
    logic                  irq_req;

    // One compare and one state slot per alarm.
    for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
        alarm_match u_match (
            .live_time (live_time),
            .target    (alm_time[i*TIME_W +: TIME_W]),
            .fmask     (alm_fmask[i*NUM_FIELDS +: NUM_FIELDS]),
            .hit       (hit[i])
        );

        alarm_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .sec_tick  (sec_tick),
            .hit       (hit[i]),
            .repeat_en (alm_repeat[i]),
            .arm       (alm_arm[i]),
            .clr       (flag_clr[i]),
            .armed     (alm_armed[i]),
            .flag      (alm_flag[i])
        );
    end

    // Interrupt request while any enabled flag is set.
    always_comb irq_req = |(alm_flag & alm_irq_en);

    pin_mux u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_sel    (pin_sel),
        .irq_req    (irq_req),
        .wave_1hz   (wave_1hz),
        .wave_100hz (wave_100hz),
        .wave_32k   (wave_32k),
        .pin_out    (pin_out)
    );

endmodule

// File: rtl/rtc_alarm_unit_chk.sv
// Checker: temporal properties of the alarm unit, observed at its ports.
module rtc_alarm_unit_chk
    import rtc_alarm_pkg::*;
#(
    parameter int NUM_ALARMS = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             sec_tick,
    input logic [NUM_ALARMS*NUM_FIELDS-1:0] alm_fmask,
    input logic [NUM_ALARMS-1:0]            alm_repeat,
    input logic [NUM_ALARMS-1:0]            alm_arm,
    input logic [NUM_ALARMS-1:0]            alm_irq_en,
    input logic [NUM_ALARMS-1:0]            flag_clr,
    input logic [1:0]                       pin_sel,
    input logic                             wave_1hz,
    input logic                             wave_100hz,
    input logic                             wave_32k,
    input logic [NUM_ALARMS-1:0]            alm_armed,
    input logic [NUM_ALARMS-1:0]            alm_flag,
    input logic                             pin_out
);

    for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_chk
        p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            alm_flag[i] && !flag_clr[i] |=> alm_flag[i]);
        p_tick_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !sec_tick && !alm_flag[i] |=> !alm_flag[i]);
        p_all_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (alm_fmask[i*NUM_FIELDS +: NUM_FIELDS] == '0) && !alm_flag[i] |=> !alm_flag[i]);
        p_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(alm_flag[i]) && !$past(alm_repeat[i]) && !$past(alm_arm[i]) |-> !alm_armed[i]);
        p_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(alm_flag[i]) && $past(alm_repeat[i]) |-> alm_armed[i]);
        p_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
            alm_arm[i] |=> alm_armed[i]);
    end

    p_irq_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pin_sel == 2'b00 && (|(alm_flag & alm_irq_en)) |=> !pin_out);
    p_irq_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pin_sel == 2'b00 && !(|(alm_flag & alm_irq_en)) |=> pin_out);
    p_wave32k_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pin_sel == 2'b01 |=> pin_out == $past(wave_32k));
    p_wave100_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pin_sel == 2'b10 |=> pin_out == $past(wave_100hz));
    p_wave1hz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pin_sel == 2'b11 |=> pin_out == $past(wave_1hz));

endmodule

bind rtc_alarm_unit rtc_alarm_unit_chk #(.NUM_ALARMS(NUM_ALARMS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .alm_fmask  (alm_fmask),
    .alm_repeat (alm_repeat),
    .alm_arm    (alm_arm),
    .alm_irq_en (alm_irq_en),
    .flag_clr   (flag_clr),
    .pin_sel    (pin_sel),
    .wave_1hz   (wave_1hz),
    .wave_100hz (wave_100hz),
    .wave_32k   (wave_32k),
    .alm_armed  (alm_armed),
    .alm_flag   (alm_flag),
    .pin_out    (pin_out)
);

// File: tb/rtc_alarm_unit_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module rtc_alarm_unit_bench;
    import rtc_alarm_pkg::*;

    localparam int N = 2;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     sec_tick = 1'b0;
    logic [TIME_W-1:0]        live_time = '0;
    logic [N*TIME_W-1:0]      alm_time = '0;
    logic [N*NUM_FIELDS-1:0]  alm_fmask = '0;
    logic [N-1:0]             alm_repeat = '0;
    logic [N-1:0]             alm_arm = '0;
    logic [N-1:0]             alm_irq_en = '0;
    logic [N-1:0]             flag_clr = '0;
    logic [1:0]               pin_sel = 2'b00;
    logic                     wave_1hz = 1'b0;
    logic                     wave_100hz = 1'b0;
    logic                     wave_32k = 1'b0;
    logic [N-1:0]             alm_armed;
    logic [N-1:0]             alm_flag;
    logic                     pin_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rtc_alarm_unit #(.NUM_ALARMS(N)) u_rtc_alarm_unit (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .live_time(live_time),
        .alm_time(alm_time), .alm_fmask(alm_fmask), .alm_repeat(alm_repeat),
        .alm_arm(alm_arm), .alm_irq_en(alm_irq_en), .flag_clr(flag_clr),
        .pin_sel(pin_sel), .wave_1hz(wave_1hz), .wave_100hz(wave_100hz),
        .wave_32k(wave_32k), .alm_armed(alm_armed), .alm_flag(alm_flag),
        .pin_out(pin_out)
    );

    function automatic logic [TIME_W-1:0] mk(input int mo, input int dt, input int dw,
                                             input int hr, input int mi, input int se);
        mk = {mo[3:0], dt[4:0], dw[2:0], hr[4:0], mi[5:0], se[5:0]};
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sec_tick = 0; alm_arm = '0; flag_clr = '0;
        alm_repeat = '0; alm_irq_en = '0; alm_fmask = '0; pin_sel = 2'b00;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic set_alarm(input int idx, input logic [TIME_W-1:0] t,
                             input logic [NUM_FIELDS-1:0] m, input logic rpt);
        alm_time[idx*TIME_W +: TIME_W] = t;
        alm_fmask[idx*NUM_FIELDS +: NUM_FIELDS] = m;
        alm_repeat[idx] = rpt;
    endtask

    task automatic arm(input logic [N-1:0] which);
        alm_arm = which; step(); alm_arm = '0;
    endtask

    task automatic tick();
        sec_tick = 1'b1; step(); sec_tick = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        step();
        chk("R11 armed after reset", alm_armed, 0);
        chk("R11 flags after reset", alm_flag, 0);
        chk("R11 pin after reset", pin_out, 1);
    endtask

    task automatic t_full_match();
        do_reset();
        live_time = mk(3, 21, 2, 5, 23, 0);
        set_alarm(0, mk(3, 21, 2, 5, 23, 0), 6'b111111, 0);
        set_alarm(1, mk(3, 21, 2, 5, 24, 0), 6'b111111, 0);
        arm(2'b11);
        tick();
        chk("R1 full match sets flag0", alm_flag[0], 1);
        chk("R1 minute mismatch no flag1", alm_flag[1], 0);
        chk("R5 one-shot disarms alarm0", alm_armed[0], 0);
        chk("R12 alarm1 stays armed", alm_armed[1], 1);
        flag_clr = 2'b01; step(); flag_clr = '0;
        tick();
        chk("R5 disarmed alarm does not fire", alm_flag[0], 0);
    endtask

    task automatic t_mask();
        do_reset();
        live_time = mk(7, 4, 3, 11, 40, 30);
        set_alarm(0, mk(1, 1, 1, 1, 1, 30), 6'b000001, 0);
        set_alarm(1, mk(7, 4, 2, 11, 40, 30), 6'b001000, 0);
        arm(2'b11);
        tick();
        chk("R2 second-only mask fires", alm_flag[0], 1);
        chk("R2 weekday-only mask mismatch", alm_flag[1], 0);
    endtask

    task automatic t_all_masked();
        do_reset();
        live_time = mk(3, 21, 2, 5, 23, 0);
        set_alarm(0, mk(3, 21, 2, 5, 23, 0), 6'b000000, 0);
        arm(2'b01);
        tick(); tick();
        chk("R3 empty mask never fires", alm_flag[0], 0);
        chk("R3 empty mask stays armed", alm_armed[0], 1);
    endtask

    task automatic t_no_tick();
        do_reset();
        live_time = mk(3, 21, 2, 5, 23, 0);
        set_alarm(0, mk(3, 21, 2, 5, 23, 0), 6'b111111, 0);
        arm(2'b01);
        repeat (5) step();
        chk("R4 no fire without tick", alm_flag[0], 0);
        chk("R4 still armed without tick", alm_armed[0], 1);
    endtask

    task automatic t_repeat();
        do_reset();
        live_time = mk(3, 21, 2, 5, 23, 10);
        set_alarm(0, mk(0, 0, 0, 0, 0, 10), 6'b000001, 1);
        arm(2'b01);
        tick();
        chk("R6 repeat fires", alm_flag[0], 1);
        chk("R6 repeat stays armed", alm_armed[0], 1);
        flag_clr = 2'b01; step(); flag_clr = '0;
        chk("R7 clear strobe clears flag", alm_flag[0], 0);
        tick();
        chk("R6 repeat fires again", alm_flag[0], 1);
        flag_clr = 2'b01; sec_tick = 1'b1; step(); flag_clr = '0; sec_tick = 1'b0;
        chk("R7 fire wins over clear", alm_flag[0], 1);
        repeat (3) step();
        chk("R7 flag sticky", alm_flag[0], 1);
    endtask

    task automatic t_arm_priority();
        do_reset();
        live_time = mk(3, 21, 2, 5, 23, 0);
        set_alarm(0, mk(3, 21, 2, 5, 23, 0), 6'b111111, 0);
        arm(2'b01);
        alm_arm = 2'b01; sec_tick = 1'b1; step(); alm_arm = '0; sec_tick = 1'b0;
        chk("R8 arm beats self-disarm", alm_armed[0], 1);
        chk("R8 fire on same edge flags", alm_flag[0], 1);
    endtask

    task automatic t_pin_irq();
        do_reset();
        live_time = mk(3, 21, 2, 5, 23, 0);
        set_alarm(0, mk(3, 21, 2, 5, 23, 0), 6'b111111, 0);
        set_alarm(1, mk(3, 21, 2, 5, 23, 0), 6'b111111, 0);
        alm_irq_en = 2'b10;
        arm(2'b01);
        tick(); step();
        chk("R9 flag without irq enable keeps pin high", pin_out, 1);
        alm_irq_en = 2'b01; step();
        chk("R9 enabled flag drives pin low", pin_out, 0);
        chk("R12 alarm1 untouched", {alm_flag[1], alm_armed[1]}, 0);
        flag_clr = 2'b01; step(); flag_clr = '0; step();
        chk("R9 pin high after clear", pin_out, 1);
    endtask

    task automatic t_freq();
        do_reset();
        for (int code = 1; code < 4; code++) begin
            pin_sel = code[1:0];
            wave_32k = (code == 1); wave_100hz = (code == 2); wave_1hz = (code == 3);
            step();
            chk($sformatf("R10 code %0d selected wave high", code), pin_out, 1);
            wave_32k = (code != 1); wave_100hz = (code != 2); wave_1hz = (code != 3);
            step();
            chk($sformatf("R10 code %0d selected wave low", code), pin_out, 0);
        end
        pin_sel = 2'b00; step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_full_match();
        t_mask();
        t_all_masked();
        t_no_tick();
        t_repeat();
        t_arm_priority();
        t_pin_irq();
        t_freq();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule